// File: doc/BRIEF.md
# Inter-Processor Doorbell Interrupt Register

This block is a 32-bit doorbell word that lets remote processor cores get the attention of a host processor. The upper 28 bits form a set of independent source flags, one per remote source. A remote core raises its flag with a single-cycle strobe. The host reads the word to find out which sources are waiting. It then writes the same value back, which clears exactly the flags it saw, because a write clears every bit where it carries a one.

The four low bits carry no state and always read as zero. A single interrupt line goes to the host's primary interrupt controller, which treats it as rising-edge sensitive. The line pulses high for one cycle each time a source flag becomes newly pending. This covers a flag arriving into an empty word, a flag arriving while others are still waiting, and a flag re-raised in the same cycle the host clears it. Masking of single sources and dispatch to handlers are left to host software.

Top module: `ipc_doorbell`

## Requirements
- R1: After synchronous reset the read word is all zeros and the interrupt output is low.
- R2: A cycle with `ring_valid` high sets source flag i (read-word bit 4+i) for every set bit i of `ring_mask`, visible on `host_rdata` in the following cycle.
- R3: Flags accumulate across strobes, and `ring_mask` has no effect in a cycle where `ring_valid` is low.
- R4: A cycle with `host_wr_en` high clears every flag whose read-word bit in `host_wdata` is one and leaves flags written as zero unchanged.
- R5: Writing back a previously read value clears only the flags in that value, so a flag raised after the read survives the write-back.
- R6: Writing all ones clears every source flag.
- R7: Read-word bits 3:0 always read zero, and writing ones to them changes nothing.
- R8: When a set strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Raising one or more flags while none are pending drives `host_irq` high for exactly one cycle, in the cycle the flags first appear on `host_rdata`.
- R10: Raising a flag that is not pending while other flags are pending pulses `host_irq`. A strobe whose bits are all already pending, and not being cleared, does not pulse it.
- R11: A flag re-raised in the same cycle that the host clears it counts as a new event and pulses `host_irq`.
- R12: With `host_wr_en` low, `host_wdata` has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_valid | input | 1 | Remote set strobe, one cycle per request |
| ring_mask | input | 28 | Sources to raise; bit i maps to read-word bit 4+i |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data; ones clear the matching flags |
| host_rdata | output | 32 | Current doorbell word, bits 3:0 zero |
| host_irq | output | 1 | One-cycle pulse on each newly pending source |

## Verification
The hardest case to reach from the ports is a set strobe and a host clear landing on the same flag in the same cycle. In that case the flag must remain set and the interrupt must still pulse. The stimulus first raises a flag. It then issues the host write-back and the remote strobe for that flag together in one cycle, and separately repeats this while unrelated flags are being cleared. A long stretch of randomly overlapping strobes and writes, checked against a per-clock reference model, adds many more such collisions.

// File: rtl/ipc_doorbell_pkg.sv
package ipc_doorbell_pkg;
  localparam int unsigned DB_WORD_W  = 32;
  localparam int unsigned DB_SRC_LSB = 4;
endpackage

// File: rtl/doorbell_clear_decode.sv
module doorbell_clear_decode #(
  parameter int WORD_W  = 32,
  parameter int SRC_LSB = 4,
  localparam int NUM_SRC = WORD_W - SRC_LSB
) (
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [NUM_SRC-1:0] clr_mask
);
  logic [NUM_SRC-1:0] field;
  // Reserved low bits are shifted out and so can never clear anything.
  assign field    = NUM_SRC'(host_wdata >> SRC_LSB);
  assign clr_mask = host_wr_en ? field : '0;
endmodule

// File: rtl/doorbell_flag_bank.sv
module doorbell_flag_bank #(
  parameter int NUM_SRC = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_mask,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_SRC-1:0] fresh
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic flag_q;
    logic kept;
    assign kept = flag_q & ~clr_mask[i];
    // New event: a set on a position that would otherwise be empty.
    assign fresh[i]   = set_mask[i] & ~kept;
    assign pending[i] = flag_q;
    always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b0;
      else     flag_q <= kept | set_mask[i];
    end
  end
endmodule

// File: rtl/doorbell_pulse_gen.sv
module doorbell_pulse_gen #(
  parameter int NUM_SRC = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] fresh,
  output logic               irq
);
  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |fresh;
  end
  assign irq = irq_q;
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
  import ipc_doorbell_pkg::*;
#(
  parameter int WORD_W  = DB_WORD_W,
  parameter int SRC_LSB = DB_SRC_LSB,
  localparam int NUM_SRC = WORD_W - SRC_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ring_valid,
  input  logic [NUM_SRC-1:0] ring_mask,
  input  logic               host_wr_en,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  output logic               host_irq
);
  logic [NUM_SRC-1:0] set_mask;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] fresh;

  assign set_mask = ring_valid ? ring_mask : '0;

  doorbell_clear_decode #(.WORD_W(WORD_W), .SRC_LSB(SRC_LSB)) u_clr (
    .host_wr_en (host_wr_en),
    .host_wdata (host_wdata),
    .clr_mask   (clr_mask)
  );

  doorbell_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .pending  (pending),
    .fresh    (fresh)
  );

  doorbell_pulse_gen #(.NUM_SRC(NUM_SRC)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .fresh (fresh),
    .irq   (host_irq)
  );

  assign host_rdata = {pending, {SRC_LSB{1'b0}}};
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk #(
  parameter int WORD_W  = 32,
  parameter int SRC_LSB = 4,
  localparam int NUM_SRC = WORD_W - SRC_LSB
) (
  input logic               clk,
  input logic               rst,
  input logic               ring_valid,
  input logic [NUM_SRC-1:0] ring_mask,
  input logic               host_wr_en,
  input logic [WORD_W-1:0]  host_wdata,
  input logic [WORD_W-1:0]  host_rdata,
  input logic               host_irq
);
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    ring_valid |=> ((host_rdata[WORD_W-1:SRC_LSB] & $past(ring_mask)) == $past(ring_mask))); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && !ring_valid) |=> ((host_rdata[WORD_W-1:SRC_LSB] & $past(host_wdata[WORD_W-1:SRC_LSB])) == '0)); // R4
  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (rst)
    !ring_valid |=> ((host_rdata & ~$past(host_rdata)) == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ring_valid && !host_wr_en) |=> $stable(host_rdata)); // R12
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> ($past(ring_valid) && host_rdata != '0)); // R9
endmodule

bind ipc_doorbell ipc_doorbell_chk #(.WORD_W(WORD_W), .SRC_LSB(SRC_LSB)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ring_valid (ring_valid),
  .ring_mask  (ring_mask),
  .host_wr_en (host_wr_en),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .host_irq   (host_irq)
);

// File: tb/ipc_doorbell_tb.sv
module ipc_doorbell_tb;
  localparam int W  = 32;
  localparam int LB = 4;
  localparam int NS = W - LB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ring_valid = 1'b0;
  logic [NS-1:0] ring_mask = '0;
  logic          host_wr_en = 1'b0;
  logic [W-1:0]  host_wdata = '0;
  logic [W-1:0]  host_rdata;
  logic          host_irq;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  string phase  = "R1";

  logic [NS-1:0] m_pend = '0;
  logic          m_irq  = 1'b0;

  always #2 clk = ~clk;

  ipc_doorbell u_dut (
    .clk(clk), .rst(rst), .ring_valid(ring_valid), .ring_mask(ring_mask),
    .host_wr_en(host_wr_en), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_irq(host_irq)
  );

  // Behavioural reference built from the requirements.
  always @(posedge clk) begin
    logic [NS-1:0] keep;
    logic [NS-1:0] setm;
    if (rst) begin
      m_pend <= '0;
      m_irq  <= 1'b0;
    end else begin
      keep = host_wr_en ? (m_pend & ~host_wdata[W-1:LB]) : m_pend;
      setm = ring_valid ? ring_mask : '0;
      m_pend <= keep | setm;
      m_irq  <= |(setm & ~keep);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_run++;
      if (host_rdata !== {m_pend, 4'b0000} || host_irq !== m_irq) begin
        n_fail++;
        $display("FAIL %s model: rdata=%h irq=%b expected rdata=%h irq=%b",
                 phase, host_rdata, host_irq, {m_pend, 4'b0000}, m_irq);
      end
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rv, input logic [NS-1:0] m, input logic we, input logic [W-1:0] wd);
    ring_valid = rv; ring_mask = m; host_wr_en = we; host_wdata = wd;
    @(negedge clk);
    ring_valid = 1'b0; ring_mask = '0; host_wr_en = 1'b0; host_wdata = '0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    logic [W-1:0] snap;
    repeat (3) @(negedge clk);
    check("R1 rdata", host_rdata, '0);
    check("R1 irq", {31'b0, host_irq}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    phase = "R9";
    cyc(1, 28'h0000001, 0, 0);
    check("R2 first set", host_rdata, 32'h10);
    check("R9 pulse", {31'b0, host_irq}, 32'd1);
    cyc(0, 0, 0, 0);
    check("R9 single cycle", {31'b0, host_irq}, 32'd0);

    phase = "R10";
    cyc(1, 28'h0000004, 0, 0);
    check("R3 accumulate", host_rdata, 32'h50);
    check("R10 new while pending", {31'b0, host_irq}, 32'd1);
    cyc(1, 28'h0000001, 0, 0);
    check("R10 repeat no pulse", {31'b0, host_irq}, 32'd0);

    phase = "R3";
    cyc(0, 28'hFFFF00F, 0, 0);
    check("R3 mask ignored", host_rdata, 32'h50);

    phase = "R12";
    cyc(0, 0, 0, 32'hFFFFFFFF);
    check("R12 write disabled", host_rdata, 32'h50);

    phase = "R4";
    cyc(0, 0, 1, 32'h10);
    check("R4 w1c", host_rdata, 32'h40);

    phase = "R5";
    snap = host_rdata;
    cyc(1, 28'h0000008, 0, 0);
    cyc(0, 0, 1, snap);
    check("R5 write-back", host_rdata, 32'h80);

    phase = "R7";
    cyc(0, 0, 1, 32'h0000000F);
    check("R7 reserved write", host_rdata, 32'h80);
    check("R7 low bits", {28'b0, host_rdata[3:0]}, 32'd0);

    phase = "R11";
    cyc(1, 28'h0000008, 1, 32'h80);
    check("R8 set wins", host_rdata, 32'h80);
    check("R11 pulse on collide", {31'b0, host_irq}, 32'd1);
    cyc(1, 28'h0000100, 0, 0);
    cyc(1, 28'h0000008, 1, 32'hFFFFFFF0);
    check("R8 set wins amid clear", host_rdata, 32'h80);

    phase = "R6";
    cyc(1, 28'hFFFFFFF, 0, 0);
    check("R2 all set", host_rdata, 32'hFFFFFFF0);
    cyc(0, 0, 1, 32'hFFFFFFFF);
    check("R6 clear all", host_rdata, 32'h0);
    cyc(1, 28'h8000001, 0, 0);
    check("R9 multi-hot pulse", {31'b0, host_irq}, 32'd1);
    check("R2 multi-hot", host_rdata, 32'h80000010);

    phase = "R8 stream";
    for (int k = 0; k < 400; k++) begin
      logic [NS-1:0] m;
      logic [W-1:0]  wd;
      m  = NS'($urandom) & NS'($urandom);
      wd = $urandom | $urandom;
      cyc(1'($urandom), m, 1'($urandom), wd);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule